// File: doc/BRIEF.md
# Gated serial-in parallel-out shifter

An eight-stage shift register whose serial input is the AND of two data lines, so either line can serve as an enable for the other. Every stage is visible on a parallel output bus, with bit 0 as the entry stage. Each shift moves every stage one place toward the top bit and loads the gated bit into bit 0. An active-low asynchronous clear empties the register at once and takes priority over everything else.

The register shifts only on a one-cycle enable that a parameterised divider produces in the system clock domain. The divider sets the shift rate, which is meant to be slow enough to see (a few hundred hertz up to about a kilohertz). A mode input picks the source of the entry bit: the gated external data, or a built-in pattern sequencer. The sequencer loads ones for eight shifts and then zeros for eight shifts, and repeats, so that a bar grows from bit 0 and then empties from bit 0. A strobe output marks each shift, so a model can be compared after every step.

Top module: `gated_sipo_shifter`

## Requirements
- R1: `q` has one bit per stage. Bit 0 is the entry stage and bit 7 is the last stage. `q` reads all zeros while `clr_n` is low.
- R2: In external mode (`auto_mode` = 0), the bit loaded into `q[0]` on a shift is `din_a & din_b`, as sampled at that shift edge.
- R3: On each shift, `q[i]` takes the previous value of `q[i-1]` for i = 1..7.
- R4: A low `clr_n` sets `q` to zero without waiting for a clock edge. While `clr_n` stays low, `q` holds zero and `shift_stb` holds low, whatever the data inputs do.
- R5: A shift happens once every `TICK_DIV` clocks. `shift_stb` is high for exactly one clock, and that clock is the first cycle in which the shifted value appears on `q`.
- R6: In internal mode (`auto_mode` = 1), the entry bit is 1 for eight consecutive shifts and then 0 for eight consecutive shifts. This 16-shift cycle repeats, so `q` fills from bit 0 upward and then drains from bit 0 upward.
- R7: After `clr_n` rises, the first shift comes `TICK_DIV` clocks later. In internal mode that first shift loads a 1, which is the start of the fill phase.
- R8: A synchronous `rst` restarts the divider and the sequencer but leaves `q` unchanged. After `rst`, the next shift comes `TICK_DIV` clocks later and, in internal mode, loads a 1.
- R9: In internal mode, `din_a` and `din_b` have no effect on `q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous restart of the divider and sequencer, active high |
| clr_n | input | 1 | Asynchronous clear of the register, active low |
| din_a | input | 1 | Serial data input, ANDed with `din_b` |
| din_b | input | 1 | Serial data input, ANDed with `din_a` |
| auto_mode | input | 1 | 1 selects the internal fill/drain pattern, 0 selects the gated data inputs |
| q | output | STAGES | Parallel stage outputs, bit 0 being the entry stage |
| shift_stb | output | 1 | High for one clock after each shift |

## Verification
Two pairs of events can fall in the same cycle. The first pair is the asynchronous clear and a pending shift. The bench drops `clr_n` between clock edges while `q` holds a non-zero pattern and the data inputs are high. It expects `q` to read zero before the next edge, and it expects `q` to stay zero with no strobe across a full divider period. The second pair is the synchronous restart and the divider count. `rst` is raised partway through a divider period during the drain phase. The bench judges the result by the unchanged `q`, by a first shift a full `TICK_DIV` clocks after release, and by an entered 1 where continuing the drain would have entered a 0.

// File: rtl/gated_sipo_shifter.sv
module gated_sipo_shifter #(
  parameter int STAGES   = 8,
  parameter int TICK_DIV = 50000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_n,
  input  logic              din_a,
  input  logic              din_b,
  input  logic              auto_mode,
  output logic [STAGES-1:0] q,
  output logic              shift_stb
);
  localparam int CW   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int PW   = $clog2(2 * STAGES);
  localparam int PLEN = 2 * STAGES;

  logic [CW-1:0] div_cnt;
  logic [PW-1:0] phase;
  logic          tick;
  logic          seq_bit;
  logic          ser_in;

  assign tick    = !rst && (div_cnt == CW'(TICK_DIV - 1));
  assign seq_bit = (phase < PW'(STAGES));
  assign ser_in  = auto_mode ? seq_bit : (din_a & din_b);

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)          div_cnt <= '0;
    else if (rst || tick) div_cnt <= '0;
    else                 div_cnt <= div_cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)                 phase <= '0;
    else if (rst)               phase <= '0;
    else if (tick && auto_mode) phase <= (phase == PW'(PLEN - 1)) ? '0 : phase + PW'(1);
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)   q <= '0;
    else if (tick) q <= {q[STAGES-2:0], ser_in};
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) shift_stb <= 1'b0;
    else        shift_stb <= tick;
  end

  a_r3_stages_move: assert property (@(posedge clk) disable iff (!clr_n)
    shift_stb |-> q[STAGES-1:1] == $past(q[STAGES-2:0]));

  a_r2_gated_entry: assert property (@(posedge clk) disable iff (!clr_n)
    (shift_stb && !$past(auto_mode)) |-> q[0] == $past(din_a & din_b));

  a_r4_clear_holds: assert property (@(posedge clk) disable iff (rst)
    !clr_n |-> (q == '0 && !shift_stb));

  a_r8_rst_keeps_q: assert property (@(posedge clk) disable iff (!clr_n)
    rst |=> q == $past(q));

  generate
    if (TICK_DIV > 1) begin : g_stb_chk
      a_r5_stb_single: assert property (@(posedge clk) disable iff (!clr_n)
        shift_stb |=> !shift_stb);
    end
  endgenerate
endmodule

// File: tb/gated_sipo_shifter_tb.sv
module gated_sipo_shifter_tb;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst, clr_n, din_a, din_b, auto_mode;
  logic [7:0] q;
  logic       shift_stb;
  int         n_vec = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  // {din_a, din_b, expected q} for consecutive shifts starting from q = 00
  localparam logic [9:0] VEC [12] = '{
    {2'b11, 8'h01}, {2'b11, 8'h03}, {2'b10, 8'h06}, {2'b01, 8'h0C},
    {2'b11, 8'h19}, {2'b11, 8'h33}, {2'b00, 8'h66}, {2'b11, 8'hCD},
    {2'b11, 8'h9B}, {2'b11, 8'h37}, {2'b11, 8'h6F}, {2'b01, 8'hDE}
  };

  gated_sipo_shifter #(.STAGES(8), .TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .clr_n(clr_n), .din_a(din_a), .din_b(din_b),
    .auto_mode(auto_mode), .q(q), .shift_stb(shift_stb)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_stb(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!shift_stb && n < 100);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    logic [7:0] mq;
    rst = 1'b1; clr_n = 1'b0; din_a = 1'b0; din_b = 1'b0; auto_mode = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset q", q, 8'h00);
    chk("R4 reset stb", {7'b0, shift_stb}, 8'h00);
    rst = 1'b0; clr_n = 1'b1;

    // R2 R3 external gated entry and movement
    for (int i = 0; i < 12; i++) begin
      {din_a, din_b} = VEC[i][9:8];
      wait_stb(n);
      chk($sformatf("R2/R3 vec %0d", i), q, VEC[i][7:0]);
      chk(i == 0 ? "R7 first shift delay" : "R5 shift period", 8'(n), 8'(DIV));
    end
    wait_stb(n);
    mq = q;
    @(negedge clk);
    chk("R5 strobe width", {7'b0, shift_stb}, 8'h00);
    chk("R5 q held between shifts", q, mq);

    // R4 asynchronous clear between edges, held across a full divider period
    chk("R4 precondition nonzero", 8'(q != 8'h00), 8'h01);
    #3 clr_n = 1'b0; din_a = 1'b1; din_b = 1'b1;
    #1 chk("R4 immediate clear", q, 8'h00);
    repeat (2 * DIV) begin
      @(negedge clk);
      chk("R4 clear holds q", q, 8'h00);
      chk("R4 clear holds stb", {7'b0, shift_stb}, 8'h00);
    end

    // R6 R7 R9 internal pattern from a fresh release
    auto_mode = 1'b1; din_a = 1'b0; din_b = 1'b0;
    clr_n = 1'b1;
    mq = 8'h00;
    for (int k = 1; k <= 26; k++) begin
      wait_stb(n);
      if (k == 1) chk("R7 delay after release", 8'(n), 8'(DIV));
      mq = {mq[6:0], (((k - 1) % 16) < 8)};
      chk($sformatf("R6 pattern shift %0d", k), q, mq);
      if (k == 9)  begin din_a = 1'b1; din_b = 1'b1; end
      if (k == 20) begin din_a = 1'b1; din_b = 1'b0; end
    end
    chk("R9 drain with data high", q, 8'hFC);

    // R8 synchronous restart partway through a divider period, in drain phase
    din_a = 1'b0; din_b = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R8 q unchanged by rst", q, 8'hFC);
    wait_stb(n);
    chk("R8 divider restarted", 8'(n), 8'(DIV));
    chk("R8 sequencer back to fill", q, 8'hF9);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule